// File: doc/BRIEF.md
# Partitioned SIMD Integer Adder

This block is a 128-bit integer adder whose carry chain is cut at lane boundaries chosen at run time. A single operation therefore produces sixteen 8-bit sums, eight 16-bit sums, four 32-bit sums, two 64-bit sums or one 128-bit sum. Every lane of an operation is computed in the same cycle, and the result is registered.

The datapath is built from byte-wide adder slices that are chained in order. A small decoder turns the 3-bit lane-size code into two masks: one marks the first byte of each lane and the other marks the last byte. At a lane start the incoming carry is replaced by the operation's own carry-in, so no carry can leak from one lane into the next. An optional subtract control inverts the second operand and forces a carry-in of one at the bottom of every lane. Lane data is integer only. The same bits are correct whether the lanes are read as signed or as unsigned values.

Top module: `simd_lane_adder`

## Requirements
- R1: For mode codes 0, 1, 2, 3 and 4, the lanes are 8, 16, 32, 64 and 128 bits wide, and lane k occupies bits [k*w + w-1 : k*w]. Each lane of sum_o equals (a + b) mod 2^w for that lane.
- R2: No carry crosses a lane boundary. An all-ones lane plus one gives zero in that lane and leaves the lane above it unchanged.
- R3: Mode codes 5, 6 and 7 are reserved and behave exactly like code 4 (one 128-bit lane).
- R4: When sub_i is 1, each lane of sum_o equals (a - b) mod 2^w. This is done by inverting b and injecting a carry of 1 into the lowest byte of every lane.
- R5: carry_o has one bit per byte. Bit j is the carry out of byte j when byte j is the top byte of a lane, and zero otherwise. For addition it is the unsigned overflow of the lane. For subtraction it is 1 exactly when the lane of a is greater than or equal to the lane of b as unsigned values.
- R6: valid_o equals valid_i as sampled at the previous rising edge. The result of an operation appears on sum_o and carry_o at that same edge.
- R7: While valid_i is low, sum_o and carry_o keep their previous values whatever the operands do.
- R8: Reset is synchronous and active high. It clears valid_o, sum_o and carry_o to zero.
- R9: Signed lane data gives two's-complement wraparound results from the same logic. For example, -1 + -1 gives 0xFE in every 8-bit lane, with carry set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation strobe |
| mode_i | input | 3 | Lane-size code (0=8, 1=16, 2=32, 3=64, 4..7=128 bits) |
| sub_i | input | 1 | 1 selects a - b per lane |
| a_i | input | 128 | First packed operand |
| b_i | input | 128 | Second packed operand |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| sum_o | output | 128 | Registered packed lane results |
| carry_o | output | 16 | Per-byte carry-out, meaningful at lane top bytes only |

## Verification
On every cycle, the embedded properties check the one-cycle valid timing, the holding of results between operations, and that carry flags appear only at lane-top bytes. They also check that the boundary masks follow the mode code, including the reserved codes. Only the bench's scenarios can show that the lane sums are arithmetically right. These scenarios compare each mode against a per-lane reference, both for addition and subtraction. They include all-ones operands that would leak a carry or a borrow into the neighbouring lane, and signed operands.

// File: rtl/lane_add_pkg.sv
package lane_add_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      LANE_W8   = 3'd0,
      LANE_W16  = 3'd1,
      LANE_W32  = 3'd2,
      LANE_W64  = 3'd3,
      LANE_W128 = 3'd4
   } lane_mode_e;

   // number of distinct lane sizes for a given slice count
   function automatic int mode_count(input int nslice);
      return $clog2(nslice) + 1;
   endfunction

   // log2 of slices per lane; reserved codes fold onto the widest lane
   function automatic int span_log(input int code, input int nslice);
      int top;
      top = mode_count(nslice) - 1;
      return (code > top) ? top : code;
   endfunction

endpackage

// File: rtl/lane_cut_decode.sv
module lane_cut_decode
   import lane_add_pkg::*;
#(
   parameter int NSLICE = 16
)(
   input  logic [MODE_W-1:0] mode,
   output logic [NSLICE-1:0] lane_first,
   output logic [NSLICE-1:0] lane_last
);

   localparam int NMODE = mode_count(NSLICE);

   if ((NSLICE & (NSLICE - 1)) != 0) begin : g_bad_pow2
      $error("lane_cut_decode: NSLICE must be a power of two");
   end
   if (NMODE > (1 << MODE_W)) begin : g_bad_modes
      $error("lane_cut_decode: mode code too narrow for NSLICE");
   end

   always_comb begin
      int lg;
      int span;
      lg   = span_log(int'(mode), NSLICE);
      span = 1 << lg;
      for (int i = 0; i < NSLICE; i++) begin
         lane_first[i] = ((i & (span - 1)) == 0);
         lane_last[i]  = (((i + 1) & (span - 1)) == 0);
      end
   end

endmodule

// File: rtl/byte_add_slice.sv
module byte_add_slice #(
   parameter int W            = 8,
   parameter bit CARRY_SELECT = 1'b0
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);

   if (W < 1) begin : g_bad_width
      $error("byte_add_slice: W must be positive");
   end

   if (CARRY_SELECT) begin : g_select
      // both carry outcomes precomputed, late carry only drives a mux
      logic [W:0] res_c0;
      logic [W:0] res_c1;
      assign res_c0 = {1'b0, a} + {1'b0, b};
      assign res_c1 = res_c0 + {{W{1'b0}}, 1'b1};
      assign {cout, sum} = cin ? res_c1 : res_c0;
   end else begin : g_ripple
      logic [W:0] res;
      assign res = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      assign {cout, sum} = res;
   end

endmodule

// File: rtl/lane_adder_core.sv
module lane_adder_core #(
   parameter int DATA_W       = 128,
   parameter int SLICE_W      = 8,
   parameter bit CARRY_SELECT = 1'b0,
   localparam int NSLICE      = DATA_W / SLICE_W
)(
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic [NSLICE-1:0] lane_first,
   output logic [DATA_W-1:0] sum,
   output logic [NSLICE-1:0] slice_co
);

   if (DATA_W % SLICE_W != 0) begin : g_bad_split
      $error("lane_adder_core: DATA_W must be a multiple of SLICE_W");
   end

   for (genvar i = 0; i < NSLICE; i++) begin : g_slice
      logic               ci;
      logic               co;
      logic [SLICE_W-1:0] b_eff;

      assign b_eff = b[i*SLICE_W +: SLICE_W] ^ {SLICE_W{sub}};

      if (i == 0) begin : g_head
         assign ci = lane_first[0] ? sub : 1'b0;
      end else begin : g_link
         // a lane start takes the operation carry-in, never the neighbour's
         assign ci = lane_first[i] ? sub : g_slice[i-1].co;
      end

      byte_add_slice #(
         .W            (SLICE_W),
         .CARRY_SELECT (CARRY_SELECT)
      ) u_slice (
         .a    (a[i*SLICE_W +: SLICE_W]),
         .b    (b_eff),
         .cin  (ci),
         .sum  (sum[i*SLICE_W +: SLICE_W]),
         .cout (co)
      );

      assign slice_co[i] = co;
   end

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
   import lane_add_pkg::*;
#(
   parameter int DATA_W       = 128,
   parameter int SLICE_W      = 8,
   parameter bit SUB_EN       = 1'b1,
   parameter bit CARRY_SELECT = 1'b0,
   localparam int NSLICE      = DATA_W / SLICE_W
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [2:0]        mode_i,
   input  logic              sub_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] sum_o,
   output logic [NSLICE-1:0] carry_o
);

   localparam int NMODE = mode_count(NSLICE);

   if (SLICE_W < 1 || DATA_W < SLICE_W) begin : g_bad_dims
      $error("simd_lane_adder: illegal DATA_W/SLICE_W");
   end
   if (NSLICE < 2) begin : g_bad_nslice
      $error("simd_lane_adder: need at least two slices");
   end

   logic [NSLICE-1:0] first_mask;
   logic [NSLICE-1:0] last_mask;
   logic [DATA_W-1:0] sum_n;
   logic [NSLICE-1:0] slice_co;
   logic              sub_eff;

   if (SUB_EN) begin : g_sub
      assign sub_eff = sub_i;
   end else begin : g_nosub
      assign sub_eff = 1'b0;
   end

   lane_cut_decode #(.NSLICE(NSLICE)) u_decode (
      .mode       (mode_i),
      .lane_first (first_mask),
      .lane_last  (last_mask)
   );

   lane_adder_core #(
      .DATA_W       (DATA_W),
      .SLICE_W      (SLICE_W),
      .CARRY_SELECT (CARRY_SELECT)
   ) u_core (
      .a          (a_i),
      .b          (b_i),
      .sub        (sub_eff),
      .lane_first (first_mask),
      .sum        (sum_n),
      .slice_co   (slice_co)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_o <= 1'b0;
         sum_o   <= '0;
         carry_o <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            sum_o   <= sum_n;
            carry_o <= slice_co & last_mask;
         end
      end
   end

   // R6: result strobe one edge after the request
   p_valid_rise_r6: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> valid_o);
   p_valid_idle_r6: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> !valid_o);

   // R7: results hold while no operation is issued
   p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> ($stable(sum_o) && $stable(carry_o)));

   // R5: carry flags only at lane-top bytes of the issuing mode
   p_carry_top_r5: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> ((carry_o & ~$past(last_mask)) == '0));

   // R2: byte lanes cut every boundary
   p_byte_cuts_r2: assert property (@(posedge clk) disable iff (rst)
      (mode_i == LANE_W8) |-> (&first_mask && &last_mask));

   // R3: widest and reserved codes leave the chain whole
   p_full_nocut_r3: assert property (@(posedge clk) disable iff (rst)
      (int'(mode_i) >= NMODE - 1) |->
         (first_mask == NSLICE'(1) && last_mask == {1'b1, {(NSLICE-1){1'b0}}}));

   // R1: as many lane starts as lane ends
   p_mask_balance_r1: assert property (@(posedge clk) disable iff (rst)
      $countones(first_mask) == $countones(last_mask));

endmodule

// File: tb/simd_lane_adder_test.sv
module simd_lane_adder_test;

   localparam int DW = 128;
   localparam int NS = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          valid_i = 1'b0;
   logic [2:0]    mode_i = 3'd0;
   logic          sub_i = 1'b0;
   logic [DW-1:0] a_i = '0;
   logic [DW-1:0] b_i = '0;
   logic          valid_o;
   logic [DW-1:0] sum_o;
   logic [NS-1:0] carry_o;

   always #5 clk = ~clk;

   simd_lane_adder uut (
      .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i), .sub_i(sub_i),
      .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .sum_o(sum_o), .carry_o(carry_o)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [DW-1:0] q_sum[$];
   logic [NS-1:0] q_co[$];
   int            q_tag[$];

   function automatic string tag_name(input int t);
      case (t)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         9: return "R9";
         default: return "R?";
      endcase
   endfunction

   // per-lane reference built from the lane definitions
   task automatic ref_lanes(input logic [DW-1:0] a, input logic [DW-1:0] b,
                            input logic [2:0] sel, input bit sub,
                            output logic [DW-1:0] s, output logic [NS-1:0] c);
      int lg, w, n;
      logic [DW:0] mask, la, lb, t, sh;
      lg = (sel > 3'd4) ? 4 : int'(sel);
      w  = 8 << lg;
      n  = DW / w;
      mask = ({{DW{1'b0}}, 1'b1} << w) - 1'b1;
      s = '0;
      c = '0;
      for (int l = 0; l < n; l++) begin
         la = ({1'b0, a} >> (l * w)) & mask;
         lb = ({1'b0, b} >> (l * w)) & mask;
         if (sub) lb = (~lb) & mask;
         t  = la + lb + {{DW{1'b0}}, sub};
         sh = (t & mask) << (l * w);
         s  = s | sh[DW-1:0];
         c[l * (w / 8) + (w / 8) - 1] = t[w];
      end
   endtask

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // driver: one operation per call, expected item pushed to the scoreboard
   task automatic send(input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [2:0] sel, input bit sub, input int tag);
      logic [DW-1:0] es;
      logic [NS-1:0] ec;
      @(negedge clk);
      a_i = a; b_i = b; mode_i = sel; sub_i = sub; valid_i = 1'b1;
      ref_lanes(a, b, sel, sub, es, ec);
      q_sum.push_back(es);
      q_co.push_back(ec);
      q_tag.push_back(tag);
   endtask

   // idle cycles with scrambled operands: outputs must not move (R7)
   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         valid_i = 1'b0;
         a_i = {4{$urandom()}};
         b_i = {4{$urandom()}};
         mode_i = 3'($urandom());
         sub_i = 1'($urandom());
      end
   endtask

   function automatic logic [DW-1:0] rnd128();
      return {$urandom(), $urandom(), $urandom(), $urandom()};
   endfunction

   // monitor
   logic          exp_v = 1'b0;
   logic [DW-1:0] last_sum = '0;
   logic [NS-1:0] last_co = '0;

   always @(posedge clk) exp_v <= rst ? 1'b0 : valid_i;

   always @(negedge clk) begin
      if (!rst && !done) begin
         // R6
         check(valid_o == exp_v, "R6", "valid_o", DW'(valid_o), DW'(exp_v));
         if (valid_o) begin
            if (q_sum.size() == 0) begin
               check(1'b0, "R6", "unexpected result", DW'(1), DW'(0));
            end else begin
               logic [DW-1:0] es;
               logic [NS-1:0] ec;
               int tg;
               es = q_sum.pop_front();
               ec = q_co.pop_front();
               tg = q_tag.pop_front();
               check(sum_o === es, tag_name(tg), "sum", sum_o, es);
               check(carry_o === ec, "R5", "carry", DW'(carry_o), DW'(ec));
            end
            last_sum <= sum_o;
            last_co  <= carry_o;
         end else begin
            check(sum_o === last_sum, "R7", "held sum", sum_o, last_sum);
            check(carry_o === last_co, "R7", "held carry", DW'(carry_o), DW'(last_co));
         end
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] ones;
      ones = '1;
      // R8: reset clears outputs even with a request pending
      valid_i = 1'b1;
      a_i = ones; b_i = ones;
      repeat (3) @(negedge clk);
      check(valid_o === 1'b0, "R8", "valid_o in reset", DW'(valid_o), '0);
      check(sum_o === '0, "R8", "sum_o in reset", sum_o, '0);
      check(carry_o === '0, "R8", "carry_o in reset", DW'(carry_o), '0);
      valid_i = 1'b0;
      rst = 1'b0;
      idle(2);

      for (int m = 0; m < 5; m++) begin
         // R1 random lanes, back to back
         for (int k = 0; k < 8; k++) send(rnd128(), rnd128(), 3'(m), 1'b0, 1);
         // R2 carry leak probes
         send(ones, {DW{1'b0}} | 128'h1, 3'(m), 1'b0, 2);
         send(ones, 128'h0101_0101_0101_0101_0101_0101_0101_0101, 3'(m), 1'b0, 2);
         send(ones, ones, 3'(m), 1'b0, 2);
         idle(2);
         // R4 subtraction, including borrow probes
         for (int k = 0; k < 6; k++) send(rnd128(), rnd128(), 3'(m), 1'b1, 4);
         send('0, 128'h1, 3'(m), 1'b1, 4);
         send('0, ones, 3'(m), 1'b1, 4);
         send(ones, ones, 3'(m), 1'b1, 4);
         idle(3);
      end

      // R3 reserved codes
      for (int m = 5; m < 8; m++) begin
         send(ones, 128'h1, 3'(m), 1'b0, 3);
         send(rnd128(), rnd128(), 3'(m), 1'b0, 3);
         send(rnd128(), rnd128(), 3'(m), 1'b1, 3);
         idle(1);
      end

      // R9 signed lanes: -1 + -1, -128 + -1, 127 + 1
      send(ones, ones, 3'd0, 1'b0, 9);
      send({16{8'h80}}, ones, 3'd0, 1'b0, 9);
      send({16{8'h7F}}, {16{8'h01}}, 3'd0, 1'b0, 9);
      send({8{16'hFFFE}}, {8{16'h0003}}, 3'd1, 1'b0, 9);
      idle(4);

      check(q_sum.size() == 0, "R6", "scoreboard drained",
            DW'(q_sum.size()), '0);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule